// File: doc/BRIEF.md
# Retention Failure Recovery Bit Flipper

This block runs an offline recovery pass on a multi-level-cell page whose retention-optimised read was still uncorrectable. When it is started with the ECC-failure flag set, it asks the flash interface for three reads of the page. The three reference codes sit just below, at and just above the boundary between the two highest programmed states. It then takes the page as a stream of words. Each word carries the three read results for a group of cells, plus a one-bit leak class per cell.

For every cell, the block checks whether the middle read disagrees with either outer read. A cell that does has its threshold inside the read window, and is called risky. A risky cell marked slow-leaking that the middle read saw in the lower of the two states is assumed to have drifted down. Its code is rewritten to the higher state. Fast-leaking cells and every other cell pass through as the middle read saw them. The corrected words go on toward ECC, one per cycle. When the last word has been handled, the block reports how many bits it flipped.

Top module: `rfr_bit_flipper`

## Requirements
- R1: A start pulse begins recovery only if the ECC-failure input is high in the same cycle. Otherwise the block stays idle and busy stays low.
- R2: Each recovery issues exactly three read requests, with reference codes base-step, base and base+step in that order. Each request is held, with its reference code unchanged, until the read is acknowledged.
- R3: Cell states are coded 11, 10, 00, 01 in order of rising threshold. Cell i of a word occupies bits [2i+1:2i]. A cell is risky when its middle-read code's "is 01" status differs from that of its low-read code or its high-read code.
- R4: A risky cell whose leak flag is 0 (slow-leaking) and whose middle-read code is 00 is output as 01. This flips one bit.
- R5: A risky cell whose leak flag is 1 (fast-leaking) is output unchanged as its middle-read code.
- R6: A cell that is not risky, or whose middle-read code is not 00, is output unchanged as its middle-read code.
- R7: Each word accepted during the streaming phase appears corrected exactly one cycle later with the valid output high. A word-valid input outside the streaming phase produces no output.
- R8: One cycle after the last word of the page is accepted, done pulses for a single cycle. On that cycle the flip count equals the total number of bits flipped in that recovery.
- R9: After reset, busy, done, the read request and the output valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a recovery pass |
| ecc_fail_i | input | 1 | High when the retention-optimised read failed ECC |
| ref_base_i | input | REF_W | Reference code at the boundary |
| ref_step_i | input | REF_W | Offset of the outer reads from the base |
| rd_req_o | output | 1 | Read request to the flash interface |
| rd_ref_o | output | REF_W | Reference code for the requested read |
| rd_ack_i | input | 1 | Requested read has completed |
| word_valid_i | input | 1 | A page word is present on the inputs |
| word_lo_i | input | 2*CELLS | Cell codes from the low-reference read |
| word_mid_i | input | 2*CELLS | Cell codes from the middle-reference read |
| word_hi_i | input | 2*CELLS | Cell codes from the high-reference read |
| leak_fast_i | input | CELLS | Per-cell leak class, 1 = fast-leaking |
| out_valid_o | output | 1 | Corrected word is valid |
| out_word_o | output | 2*CELLS | Corrected cell codes |
| busy_o | output | 1 | A recovery pass is in progress |
| done_o | output | 1 | One-cycle pulse at the end of the pass |
| flip_count_o | output | CNT_W | Bits flipped in the pass, valid with done |

## Verification
A sequencer stuck in a read state shows up quickly: the read request stays high, or the stream stalls, so no corrected word comes out and done never arrives. An off-by-one in the word counter shows up at the end of the page. Done then comes one word early, with corrected words still expected, or one word late, after the final word has already left. A wrong risky or leak decision, or a wrong state code, corrupts the corrected word one cycle after its input. The same fault also makes the flip count wrong at done. A count that is not cleared between passes is caught by the second recovery's done value.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_MID,
    ST_RD_HI,
    ST_STREAM,
    ST_DONE
  } rfr_state_e;

  // Codes of the two states on either side of the recovered boundary
  localparam logic [1:0] CODE_LOWER = 2'b00;
  localparam logic [1:0] CODE_UPPER = 2'b01;

  function automatic logic above_edge(input logic [1:0] code);
    return code == CODE_UPPER;
  endfunction

endpackage

// File: rtl/rfr_seq.sv
module rfr_seq
  import rfr_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int REF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ecc_fail_i,
  input  logic [REF_W-1:0] ref_base_i,
  input  logic [REF_W-1:0] ref_step_i,
  input  logic             rd_ack_i,
  input  logic             word_valid_i,
  output logic             rd_req_o,
  output logic [REF_W-1:0] rd_ref_o,
  output logic             take_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int WC_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [WC_W-1:0] LAST_WORD = WC_W'(WORDS - 1);

  rfr_state_e      state_q, state_d;
  logic [WC_W-1:0] wcnt_q, wcnt_d;
  logic [REF_W-1:0] base_q, step_q;
  logic            wcnt_en;

  assign take_o   = (state_q == ST_IDLE) && start_i && ecc_fail_i;
  assign accept_o = (state_q == ST_STREAM) && word_valid_i;
  assign wcnt_en  = take_o || accept_o;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (take_o) state_d = ST_RD_LO;
      ST_RD_LO:  if (rd_ack_i) state_d = ST_RD_MID;
      ST_RD_MID: if (rd_ack_i) state_d = ST_RD_HI;
      ST_RD_HI:  if (rd_ack_i) state_d = ST_STREAM;
      ST_STREAM: if (accept_o && (wcnt_q == LAST_WORD)) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wcnt_d = wcnt_q;
    if (take_o)        wcnt_d = '0;
    else if (accept_o) wcnt_d = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      base_q  <= '0;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      if (wcnt_en) wcnt_q <= wcnt_d;
      if (take_o) begin
        base_q <= ref_base_i;
        step_q <= ref_step_i;
      end
    end
  end

  always_comb begin
    rd_req_o = 1'b0;
    rd_ref_o = base_q;
    case (state_q)
      ST_RD_LO:  begin rd_req_o = 1'b1; rd_ref_o = base_q - step_q; end
      ST_RD_MID: begin rd_req_o = 1'b1; rd_ref_o = base_q;          end
      ST_RD_HI:  begin rd_req_o = 1'b1; rd_ref_o = base_q + step_q; end
      default:   ;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  // R2: a pending read keeps its request and reference until acknowledged
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_ref_o)));

  // R1: an idle block ignores start when ECC has not failed
  a_r1_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !ecc_fail_i) |=> !busy_o);

  // R8: done lasts a single cycle and is followed by idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

endmodule

// File: rtl/rfr_word_fix.sv
module rfr_word_fix
  import rfr_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic [2*CELLS-1:0] lo_i,
  input  logic [2*CELLS-1:0] mid_i,
  input  logic [2*CELLS-1:0] hi_i,
  input  logic [CELLS-1:0]   fast_i,
  output logic [2*CELLS-1:0] fixed_o,
  output logic [CELLS-1:0]   flip_o
);

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic [1:0] lo_c, mid_c, hi_c;
    logic       risky, raise;

    assign lo_c  = lo_i[2*c +: 2];
    assign mid_c = mid_i[2*c +: 2];
    assign hi_c  = hi_i[2*c +: 2];

    assign risky = (above_edge(mid_c) != above_edge(lo_c)) ||
                   (above_edge(mid_c) != above_edge(hi_c));
    assign raise = risky && !fast_i[c] && (mid_c == CODE_LOWER);

    assign fixed_o[2*c +: 2] = raise ? CODE_UPPER : mid_c;
    assign flip_o[c]         = raise;

    // R5: fast-leaking cells are never altered
    always_comb begin
      a_r5_fast_kept: assert (!fast_i[c] || (fixed_o[2*c +: 2] == mid_c));
    end
  end

endmodule

// File: rtl/rfr_flip_count.sv
module rfr_flip_count #(
  parameter int CELLS = 8,
  parameter int WORDS = 16,
  parameter int CNT_W = $clog2(WORDS * CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [CELLS-1:0] mask_i,
  output logic [CNT_W-1:0] count_o
);

  localparam int MAX_FLIPS = WORDS * CELLS;

  logic [CNT_W-1:0] pop, cnt_d, cnt_q;

  always_comb begin
    pop = '0;
    for (int i = 0; i < CELLS; i++) pop = pop + CNT_W'(mask_i[i]);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)   cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear_i || en_i)  cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R8: the count can never exceed one flip per cell of the page
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(MAX_FLIPS));

endmodule

// File: rtl/rfr_bit_flipper.sv
module rfr_bit_flipper #(
  parameter int CELLS = 8,
  parameter int WORDS = 16,
  parameter int REF_W = 8,
  parameter int CNT_W = $clog2(WORDS * CELLS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               ecc_fail_i,
  input  logic [REF_W-1:0]   ref_base_i,
  input  logic [REF_W-1:0]   ref_step_i,
  output logic               rd_req_o,
  output logic [REF_W-1:0]   rd_ref_o,
  input  logic               rd_ack_i,
  input  logic               word_valid_i,
  input  logic [2*CELLS-1:0] word_lo_i,
  input  logic [2*CELLS-1:0] word_mid_i,
  input  logic [2*CELLS-1:0] word_hi_i,
  input  logic [CELLS-1:0]   leak_fast_i,
  output logic               out_valid_o,
  output logic [2*CELLS-1:0] out_word_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   flip_count_o
);

  logic               take, accept;
  logic [2*CELLS-1:0] fixed;
  logic [CELLS-1:0]   flips;
  logic               oval_q;
  logic [2*CELLS-1:0] oword_q;

  rfr_seq #(.WORDS(WORDS), .REF_W(REF_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .ecc_fail_i   (ecc_fail_i),
    .ref_base_i   (ref_base_i),
    .ref_step_i   (ref_step_i),
    .rd_ack_i     (rd_ack_i),
    .word_valid_i (word_valid_i),
    .rd_req_o     (rd_req_o),
    .rd_ref_o     (rd_ref_o),
    .take_o       (take),
    .accept_o     (accept),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  rfr_word_fix #(.CELLS(CELLS)) u_fix (
    .lo_i    (word_lo_i),
    .mid_i   (word_mid_i),
    .hi_i    (word_hi_i),
    .fast_i  (leak_fast_i),
    .fixed_o (fixed),
    .flip_o  (flips)
  );

  rfr_flip_count #(.CELLS(CELLS), .WORDS(WORDS), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (take),
    .en_i    (accept),
    .mask_i  (flips),
    .count_o (flip_count_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oval_q <= 1'b0;
    else        oval_q <= accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      oword_q <= '0;
    else if (accept) oword_q <= fixed;
  end

  assign out_valid_o = oval_q;
  assign out_word_o  = oword_q;

  // R7: an output word only follows a word accepted during streaming
  a_r7_out_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(word_valid_i && busy_o && !rd_req_o && !done_o));

  // R2: no read is requested while words are being streamed out
  a_r2_no_req_with_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !rd_req_o);

endmodule

// File: tb/test_rfr_bit_flipper.sv
module test_rfr_bit_flipper;

  localparam int CELLS = 8;
  localparam int WORDS = 16;
  localparam int REF_W = 8;
  localparam int CNT_W = $clog2(WORDS * CELLS + 1);
  localparam int W     = 2 * CELLS;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i, ecc_fail_i, rd_ack_i, word_valid_i;
  logic [REF_W-1:0] ref_base_i, ref_step_i;
  logic             rd_req_o;
  logic [REF_W-1:0] rd_ref_o;
  logic [W-1:0]     word_lo_i, word_mid_i, word_hi_i;
  logic [CELLS-1:0] leak_fast_i;
  logic             out_valid_o, busy_o, done_o;
  logic [W-1:0]     out_word_o;
  logic [CNT_W-1:0] flip_count_o;

  int checks = 0;
  int errors = 0;
  int exp_total = 0;
  bit finished = 0;
  logic [W-1:0] exp_q[$];
  logic [31:0] lfsr = 32'hACE1_2345;

  always #4 clk = ~clk;

  rfr_bit_flipper #(.CELLS(CELLS), .WORDS(WORDS), .REF_W(REF_W)) i_rfr_bit_flipper (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ecc_fail_i(ecc_fail_i),
    .ref_base_i(ref_base_i), .ref_step_i(ref_step_i),
    .rd_req_o(rd_req_o), .rd_ref_o(rd_ref_o), .rd_ack_i(rd_ack_i),
    .word_valid_i(word_valid_i), .word_lo_i(word_lo_i), .word_mid_i(word_mid_i),
    .word_hi_i(word_hi_i), .leak_fast_i(leak_fast_i),
    .out_valid_o(out_valid_o), .out_word_o(out_word_o), .busy_o(busy_o),
    .done_o(done_o), .flip_count_o(flip_count_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model from the requirements: R3 risky test, R4 raise, R5/R6 keep
  function automatic logic [W-1:0] model(input logic [W-1:0] lo, mid, hi,
                                         input logic [CELLS-1:0] fast, output int nflip);
    logic [W-1:0] r;
    nflip = 0;
    for (int c = 0; c < CELLS; c++) begin
      logic ul, um, uh;
      ul = (lo[2*c +: 2] == 2'b01);
      um = (mid[2*c +: 2] == 2'b01);
      uh = (hi[2*c +: 2] == 2'b01);
      r[2*c +: 2] = mid[2*c +: 2];
      if (((um != ul) || (um != uh)) && !fast[c] && mid[2*c +: 2] == 2'b00) begin
        r[2*c +: 2] = 2'b01;
        nflip++;
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] rep(input logic [1:0] code);
    logic [W-1:0] r;
    for (int c = 0; c < CELLS; c++) r[2*c +: 2] = code;
    return r;
  endfunction

  task automatic next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      if (exp_q.size() == 0)
        check(1'b0, "R7 unexpected output", out_word_o, 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(out_word_o == e, "R4/R5/R6 corrected word", out_word_o, e);
      end
    end
    if (rst_n && done_o) begin
      check(flip_count_o == CNT_W'(exp_total), "R8 flip count", flip_count_o, exp_total);
      check(exp_q.size() == 0, "R8 done after last word", exp_q.size(), 0);
    end
  end

  task automatic send_word(input logic [W-1:0] lo, mid, hi, input logic [CELLS-1:0] fast);
    int n;
    word_lo_i = lo; word_mid_i = mid; word_hi_i = hi; leak_fast_i = fast;
    word_valid_i = 1'b1;
    exp_q.push_back(model(lo, mid, hi, fast, n));
    exp_total += n;
    @(negedge clk);
    word_valid_i = 1'b0;
  endtask

  task automatic do_reads(input logic [REF_W-1:0] base, step);
    logic [REF_W-1:0] exp_ref[3];
    exp_ref[0] = base - step; exp_ref[1] = base; exp_ref[2] = base + step;
    for (int k = 0; k < 3; k++) begin
      int guard = 0;
      while (!rd_req_o && guard < 20) begin @(negedge clk); guard++; end
      check(rd_req_o && rd_ref_o == exp_ref[k], "R2 read reference", rd_ref_o, exp_ref[k]);
      @(negedge clk);
      check(rd_req_o && rd_ref_o == exp_ref[k], "R2 request held", rd_ref_o, exp_ref[k]);
      rd_ack_i = 1'b1;
      @(negedge clk);
      rd_ack_i = 1'b0;
    end
    check(!rd_req_o, "R2 exactly three reads", rd_req_o, 0);
  endtask

  task automatic recovery(input logic [REF_W-1:0] base, step, input bit directed);
    exp_total = 0;
    ref_base_i = base; ref_step_i = step;
    start_i = 1'b1; ecc_fail_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; ecc_fail_i = 1'b0;
    // R7: word offered during the read phase is ignored
    word_valid_i = 1'b1;
    @(negedge clk);
    word_valid_i = 1'b0;
    check(!out_valid_o, "R7 word ignored while reading", out_valid_o, 0);
    do_reads(base, step);
    for (int w = 0; w < WORDS; w++) begin
      if (directed && w == 0)      send_word(rep(2'b00), rep(2'b00), rep(2'b00), '0);  // R6 not risky
      else if (directed && w == 1) send_word(rep(2'b01), rep(2'b00), rep(2'b00), '0);  // R4 all raised
      else if (directed && w == 2) send_word(rep(2'b01), rep(2'b00), rep(2'b00), '1);  // R5 fast kept
      else if (directed && w == 3) send_word(rep(2'b01), rep(2'b01), rep(2'b00), '0);  // R6 mid is upper
      else if (directed && w == 4) send_word(rep(2'b01), rep(2'b00), rep(2'b01), 8'h0F); // R3 mid alone
      else if (directed && w == 5) send_word(rep(2'b00), rep(2'b10), rep(2'b01), '0);  // R6 mid not 00
      else begin
        logic [W-1:0] lo, mid, hi;
        next_rand(); lo = lfsr[15:0] & 16'h5555;
        next_rand(); mid = lfsr[15:0] & 16'h5555;
        next_rand(); hi = lfsr[15:0] & 16'h5555;
        next_rand();
        send_word(lo, mid, hi, lfsr[7:0]);
        if (w == 9) repeat (2) @(negedge clk);   // gap in the stream
      end
    end
    repeat (3) @(negedge clk);
    check(!busy_o, "R8 idle after done", busy_o, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 0; ecc_fail_i = 0; rd_ack_i = 0; word_valid_i = 0;
    ref_base_i = '0; ref_step_i = '0;
    word_lo_i = '0; word_mid_i = '0; word_hi_i = '0; leak_fast_i = '0;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !rd_req_o && !out_valid_o, "R9 reset state",
          {busy_o, done_o, rd_req_o, out_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: start without ECC failure is ignored
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(!busy_o && !rd_req_o, "R1 start needs ecc failure", busy_o, 0);
    @(negedge clk);
    check(!busy_o, "R1 still idle", busy_o, 0);
    recovery(8'h80, 8'h06, 1'b1);
    // R7: word in idle is ignored
    word_valid_i = 1'b1;
    @(negedge clk);
    word_valid_i = 1'b0;
    @(negedge clk);
    check(!out_valid_o, "R7 word ignored when idle", out_valid_o, 0);
    recovery(8'h40, 8'h0A, 1'b0);
    check(exp_q.size() == 0, "R7 all words delivered", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R8 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule